// File: doc/BRIEF.md
# OTG Role Detect Controller

This block is the control and status front end of a dual-role USB 2.0 port. It takes the raw ID pin and the VBUS session-valid level, passes both through a synchroniser, and records every toggle in a sticky change flag that software clears by writing one. A flag that is also enabled drives a level interrupt. A two-state machine turns the current ID and session-valid levels into a suggested role for the port.

The same register bank holds the mode bits that steer the PHY: peripheral or host select, the ID pull-up, the VBUS drive request with its source select, and the D+ and D- pull-down enable and apply bits. The outputs to the PHY are gated combinations of these bits. All registers sit on a simple 32-bit bus with a one-cycle write strobe and a registered read, where read data is valid one cycle after the read strobe.

Role FSM states: `ROLE_HOST` (reset state) and `ROLE_PERI`. Transition `HOST_TO_PERI` is taken when the reported ID level and session-valid level are both 1. Transition `PERI_TO_HOST` is taken when either of them is 0.

Top module: `otg_role_ctrl`

## Requirements
- R1: After reset, all writable bits, both change flags and both enables are 0. `irq`, every PHY control output and `role_peri_hint` are 0, and the role machine is in `ROLE_HOST`.
- R2: Each toggle of the synchronised session-valid input sets bit 12 of the status register at offset 0x604. Each toggle of the synchronised ID input sets bit 11 of that register. The flag appears within a few cycles of the pin edge.
- R3: Writing 1 to a status bit clears it. Writing 0 to it leaves it unchanged.
- R4: If a change event and a write of 1 to the same status bit occur in the same cycle, the bit stays set.
- R5: `irq` is high exactly while some status bit is 1 and the bit at the same position (11 or 12) of the enable register at 0x608 is also 1.
- R6: The register at 0x630 reads the live session-valid level at bit 20 and the live ID level at bit 19. Writes do not change these two bits. Bit 5 (ID sampling enable) and bit 4 (VBUS drive request) of the same register are read/write.
- R7: While bit 5 of 0x630 is 0, the reported ID level is held, and no ID change flag is raised.
- R8: `role_peri_hint` is 1 one cycle after the reported ID and session-valid levels are both 1. It is 0 one cycle after either level is 0.
- R9: Bit 31 of 0x600 is read/write and drives `phy_peri_mode`.
- R10: At 0x610, bit 19 is the D+ pull-down enable, bit 18 applies the D+ pull-down, bit 17 is the D- pull-down enable and bit 16 applies the D- pull-down. `phy_dp_pulldown` is bit 19 AND bit 18. `phy_dm_pulldown` is bit 17 AND bit 16.
- R11: `phy_vbus_drive` is bit 8 of 0x60C (internal source select) AND bit 4 of 0x630.
- R12: Reads of unmapped offsets return 0. Unimplemented bits of mapped registers read 0.
- R13: `phy_id_pullup` follows bit 5 of 0x630.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| id_pin | input | 1 | Raw ID level |
| sess_vld_pin | input | 1 | Raw VBUS session-valid level |
| irq | output | 1 | Level interrupt |
| phy_peri_mode | output | 1 | 1 = peripheral, 0 = host |
| phy_id_pullup | output | 1 | ID pull-up and sampling enable |
| phy_vbus_drive | output | 1 | Gated VBUS drive |
| phy_dp_pulldown | output | 1 | Gated D+ pull-down |
| phy_dm_pulldown | output | 1 | Gated D- pull-down |
| role_peri_hint | output | 1 | Suggested role, 1 = B-device (peripheral) |

## Verification
Some properties are checked by assertions on every cycle:
- a change event always leaves its flag set on the next cycle, even when a clearing write arrives with it;
- a lone write of 1 clears a flag, and a flag with no write of 1 stays set;
- the held ID level does not move while sampling is off, and no ID change is raised then;
- the role hint tracks the reported levels one cycle later.

Other behaviour only the bench scenarios can show: the register values seen through the bus, the live bits ignoring writes, unmapped reads returning zero, the interrupt gating with mismatched enables, the pull-down and VBUS gating at the PHY pins, and the exact same-cycle collision between a pin toggle and a clearing write.

// File: rtl/otg_role_pkg.sv
package otg_role_pkg;
    localparam int DATA_W = 32;

    localparam int OFS_MODE  = 'h600;
    localparam int OFS_STS   = 'h604;
    localparam int OFS_EN    = 'h608;
    localparam int OFS_VSRC  = 'h60C;
    localparam int OFS_LINE  = 'h610;
    localparam int OFS_LIVE  = 'h630;

    localparam int BIT_PERI     = 31;
    localparam int BIT_SESS_CHG = 12;
    localparam int BIT_ID_CHG   = 11;
    localparam int BIT_VSRC     = 8;
    localparam int BIT_LINE_LO  = 16;
    localparam int LINE_W       = 4;
    localparam int BIT_SESS_LVL = 20;
    localparam int BIT_ID_LVL   = 19;
    localparam int BIT_IDPU     = 5;
    localparam int BIT_DRV      = 4;

    typedef enum logic {
        ROLE_HOST = 1'b0,
        ROLE_PERI = 1'b1
    } role_t;
endpackage

// File: rtl/otg_sync.sv
module otg_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    localparam int CW = W * STAGES;

    logic [CW-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[CW-W-1:0], d};
    end

    assign q = chain[CW-1 -: W];
endmodule

// File: rtl/otg_chg_det.sv
module otg_chg_det (
    input  logic clk,
    input  logic rst_n,
    input  logic id_s,
    input  logic sess_s,
    input  logic id_samp_en,
    output logic id_lvl,
    output logic sess_lvl,
    output logic id_chg,
    output logic sess_chg
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            id_lvl   <= 1'b0;
            sess_lvl <= 1'b0;
        end else begin
            if (id_samp_en) id_lvl <= id_s;
            sess_lvl <= sess_s;
        end
    end

    assign id_chg   = id_samp_en && (id_s != id_lvl);
    assign sess_chg = (sess_s != sess_lvl);
endmodule

// File: rtl/otg_role_fsm.sv
module otg_role_fsm
    import otg_role_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic id_lvl,
    input  logic sess_lvl,
    output logic role_peri
);
    role_t st_q, st_d;
    logic  b_dev;

    assign b_dev = id_lvl && sess_lvl;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ROLE_HOST: if (b_dev)  st_d = ROLE_PERI;   // HOST_TO_PERI
            ROLE_PERI: if (!b_dev) st_d = ROLE_HOST;   // PERI_TO_HOST
            default:   st_d = ROLE_HOST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ROLE_HOST;
        else        st_q <= st_d;
    end

    always_comb begin
        role_peri = (st_q == ROLE_PERI);
    end
endmodule

// File: rtl/otg_role_ctrl.sv
module otg_role_ctrl
    import otg_role_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              id_pin,
    input  logic              sess_vld_pin,
    output logic              irq,
    output logic              phy_peri_mode,
    output logic              phy_id_pullup,
    output logic              phy_vbus_drive,
    output logic              phy_dp_pulldown,
    output logic              phy_dm_pulldown,
    output logic              role_peri_hint
);
    localparam int NCHG = 2;  // [0] = ID, [1] = session valid

    logic [1:0]        raw_in, syn_in;
    logic              id_lvl, sess_lvl, id_chg, sess_chg;
    logic [NCHG-1:0]   chg_evt, sts_q, en_q, w1c;
    logic              peri_q, vsrc_q, idpu_q, drv_q;
    logic [LINE_W-1:0] line_q;
    logic [DATA_W-1:0] rd_mux;
    logic              hit_mode, hit_sts, hit_en, hit_vsrc, hit_line, hit_live;

    assign raw_in = {sess_vld_pin, id_pin};

    otg_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn_in)
    );

    otg_chg_det u_det (
        .clk(clk), .rst_n(rst_n),
        .id_s(syn_in[0]), .sess_s(syn_in[1]), .id_samp_en(idpu_q),
        .id_lvl(id_lvl), .sess_lvl(sess_lvl),
        .id_chg(id_chg), .sess_chg(sess_chg)
    );

    otg_role_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .id_lvl(id_lvl), .sess_lvl(sess_lvl), .role_peri(role_peri_hint)
    );

    assign hit_mode = (bus_addr == ADDR_W'(OFS_MODE));
    assign hit_sts  = (bus_addr == ADDR_W'(OFS_STS));
    assign hit_en   = (bus_addr == ADDR_W'(OFS_EN));
    assign hit_vsrc = (bus_addr == ADDR_W'(OFS_VSRC));
    assign hit_line = (bus_addr == ADDR_W'(OFS_LINE));
    assign hit_live = (bus_addr == ADDR_W'(OFS_LIVE));

    assign chg_evt = {sess_chg, id_chg};
    assign w1c     = (bus_wr && hit_sts) ? {bus_wdata[BIT_SESS_CHG], bus_wdata[BIT_ID_CHG]} : '0;

    // Sticky flags: a new event beats a clearing write in the same cycle.
    generate
        for (genvar i = 0; i < NCHG; i++) begin : g_flag
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)          sts_q[i] <= 1'b0;
                else if (chg_evt[i]) sts_q[i] <= 1'b1;
                else if (w1c[i])     sts_q[i] <= 1'b0;
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            peri_q <= 1'b0;
            en_q   <= '0;
            vsrc_q <= 1'b0;
            line_q <= '0;
            idpu_q <= 1'b0;
            drv_q  <= 1'b0;
        end else if (bus_wr) begin
            if (hit_mode) peri_q <= bus_wdata[BIT_PERI];
            if (hit_en)   en_q   <= {bus_wdata[BIT_SESS_CHG], bus_wdata[BIT_ID_CHG]};
            if (hit_vsrc) vsrc_q <= bus_wdata[BIT_VSRC];
            if (hit_line) line_q <= bus_wdata[BIT_LINE_LO +: LINE_W];
            if (hit_live) begin
                idpu_q <= bus_wdata[BIT_IDPU];
                drv_q  <= bus_wdata[BIT_DRV];
            end
        end
    end

    always_comb begin
        rd_mux = '0;
        if (hit_mode) rd_mux[BIT_PERI] = peri_q;
        if (hit_sts) begin
            rd_mux[BIT_SESS_CHG] = sts_q[1];
            rd_mux[BIT_ID_CHG]   = sts_q[0];
        end
        if (hit_en) begin
            rd_mux[BIT_SESS_CHG] = en_q[1];
            rd_mux[BIT_ID_CHG]   = en_q[0];
        end
        if (hit_vsrc) rd_mux[BIT_VSRC] = vsrc_q;
        if (hit_line) rd_mux[BIT_LINE_LO +: LINE_W] = line_q;
        if (hit_live) begin
            rd_mux[BIT_SESS_LVL] = sess_lvl;
            rd_mux[BIT_ID_LVL]   = id_lvl;
            rd_mux[BIT_IDPU]     = idpu_q;
            rd_mux[BIT_DRV]      = drv_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end

    // line_q[3] D+ enable, [2] D+ apply, [1] D- enable, [0] D- apply
    assign irq             = |(sts_q & en_q);
    assign phy_peri_mode   = peri_q;
    assign phy_id_pullup   = idpu_q;
    assign phy_vbus_drive  = vsrc_q & drv_q;
    assign phy_dp_pulldown = line_q[3] & line_q[2];
    assign phy_dm_pulldown = line_q[1] & line_q[0];
endmodule

// File: rtl/otg_role_ctrl_chk.sv
module otg_role_ctrl_chk
    import otg_role_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [1:0]        sts_q,
    input logic              id_lvl,
    input logic              sess_lvl,
    input logic              id_chg,
    input logic              sess_chg,
    input logic              phy_id_pullup,
    input logic              role_peri_hint
);
    logic clr_sess;
    assign clr_sess = bus_wr && (bus_addr == ADDR_W'(OFS_STS)) && bus_wdata[BIT_SESS_CHG];

    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n) sess_chg |=> sts_q[1]); // R4
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (clr_sess && !sess_chg) |=> !sts_q[1]); // R3
    AST_W0_KEEPS: assert property (@(posedge clk) disable iff (!rst_n) (sts_q[1] && !clr_sess) |=> sts_q[1]); // R3
    AST_ID_HELD: assert property (@(posedge clk) disable iff (!rst_n) !phy_id_pullup |=> $stable(id_lvl)); // R7
    AST_NO_ID_CHG: assert property (@(posedge clk) disable iff (!rst_n) !phy_id_pullup |-> !id_chg); // R7
    AST_ROLE_PERI: assert property (@(posedge clk) disable iff (!rst_n) (id_lvl && sess_lvl) |=> role_peri_hint); // R8
    AST_ROLE_HOST: assert property (@(posedge clk) disable iff (!rst_n) !(id_lvl && sess_lvl) |=> !role_peri_hint); // R8
endmodule

bind otg_role_ctrl otg_role_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .sts_q(sts_q), .id_lvl(id_lvl), .sess_lvl(sess_lvl), .id_chg(id_chg), .sess_chg(sess_chg),
    .phy_id_pullup(phy_id_pullup), .role_peri_hint(role_peri_hint)
);

// File: tb/otg_role_ctrl_bench.sv
module otg_role_ctrl_bench;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0, bus_rd = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          id_pin = 1'b0, sess_vld_pin = 1'b0;
    logic          irq, phy_peri_mode, phy_id_pullup, phy_vbus_drive;
    logic          phy_dp_pulldown, phy_dm_pulldown, role_peri_hint;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } exp_t;
    exp_t exp_q[$];
    logic rd_d = 1'b0;

    always #5 clk = ~clk;

    otg_role_ctrl #(.ADDR_W(AW), .SYNC_STAGES(2)) u_otg_role_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .id_pin(id_pin), .sess_vld_pin(sess_vld_pin), .irq(irq),
        .phy_peri_mode(phy_peri_mode), .phy_id_pullup(phy_id_pullup),
        .phy_vbus_drive(phy_vbus_drive), .phy_dp_pulldown(phy_dp_pulldown),
        .phy_dm_pulldown(phy_dm_pulldown), .role_peri_hint(role_peri_hint)
    );

    // Monitor: read data lands on the edge after the strobe.
    always @(posedge clk) rd_d <= bus_rd;
    always @(negedge clk) begin
        if (rd_d && exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (bus_rdata !== e.exp) begin
                errors++;
                $display("FAIL %s: read got %h expected %h", e.tag, bus_rdata, e.exp);
            end
        end
    end

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(logic [AW-1:0] a, logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(logic [AW-1:0] a, logic [31:0] e, string tag);
        exp_t item;
        item.exp = e; item.tag = tag;
        exp_q.push_back(item);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic chk(logic act, logic exp, string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);

        // R1 reset state
        chk(irq, 1'b0, "R1 irq");
        chk(phy_peri_mode | phy_id_pullup | phy_vbus_drive, 1'b0, "R1 phy ctrl");
        chk(phy_dp_pulldown | phy_dm_pulldown, 1'b0, "R1 pulldowns");
        chk(role_peri_hint, 1'b0, "R1 role host");
        bus_read('h600, 32'h0, "R1 mode");
        bus_read('h604, 32'h0, "R1 status");
        bus_read('h608, 32'h0, "R1 enable");
        bus_read('h60C, 32'h0, "R1 vbus src");
        bus_read('h610, 32'h0, "R1 line");
        bus_read('h630, 32'h0, "R1 R6 live");

        // R12 unmapped and unused bits
        bus_read('h700, 32'h0, "R12 unmapped");
        bus_read('h614, 32'h0, "R12 gap");
        bus_write('h600, 32'hFFFF_FFFF);
        bus_read('h600, 32'h8000_0000, "R9 R12 mode bits");
        chk(phy_peri_mode, 1'b1, "R9 peri out");
        bus_write('h600, 32'h0);
        chk(phy_peri_mode, 1'b0, "R9 host out");

        // R10 pull-down gating
        bus_write('h610, 32'h000A_0000);
        chk(phy_dp_pulldown | phy_dm_pulldown, 1'b0, "R10 enable only");
        bus_write('h610, 32'h000F_0000);
        chk(phy_dp_pulldown & phy_dm_pulldown, 1'b1, "R10 both");
        bus_write('h610, 32'h000B_0000);
        chk(phy_dp_pulldown, 1'b0, "R10 dp off");
        chk(phy_dm_pulldown, 1'b1, "R10 dm on");
        bus_read('h610, 32'h000B_0000, "R10 readback");

        // R11 VBUS drive gating
        bus_write('h630, 32'h10);
        chk(phy_vbus_drive, 1'b0, "R11 src off");
        bus_write('h60C, 32'h100);
        chk(phy_vbus_drive, 1'b1, "R11 src on");
        bus_read('h60C, 32'h100, "R11 src readback");

        // R2 session change, R5 interrupt gating
        sess_vld_pin = 1'b1;
        wait_cyc(5);
        bus_read('h604, 32'h1000, "R2 sess flag");
        chk(irq, 1'b0, "R5 not enabled");
        bus_write('h630, 32'h0018_0010);
        bus_read('h630, 32'h0010_0010, "R6 live ignores write");
        bus_write('h608, 32'h1000);
        chk(irq, 1'b1, "R5 enabled");
        bus_write('h608, 32'h0800);
        chk(irq, 1'b0, "R5 other bit");

        // R7 ID with sampling off
        id_pin = 1'b1;
        wait_cyc(5);
        bus_read('h604, 32'h1000, "R7 no id flag");
        bus_read('h630, 32'h0010_0010, "R7 id held");
        chk(role_peri_hint, 1'b0, "R8 held id host");

        // R3 write-zero keeps, write-one clears
        bus_write('h604, 32'h0);
        bus_read('h604, 32'h1000, "R3 write zero");
        bus_write('h604, 32'h1000);
        bus_read('h604, 32'h0, "R3 write one");

        // R13 sampling on, R2 id flag, R8 role
        bus_write('h630, 32'h30);
        chk(phy_id_pullup, 1'b1, "R13 pullup");
        wait_cyc(5);
        bus_read('h604, 32'h0800, "R2 id flag");
        chk(irq, 1'b1, "R5 id enabled");
        chk(role_peri_hint, 1'b1, "R8 b-device");
        bus_read('h630, 32'h0018_0030, "R6 live levels");
        sess_vld_pin = 1'b0;
        wait_cyc(5);
        chk(role_peri_hint, 1'b0, "R8 back to host");
        bus_read('h604, 32'h1800, "R2 both flags");
        bus_write('h604, 32'h1800);
        bus_read('h604, 32'h0, "R3 clear both");
        chk(irq, 1'b0, "R5 cleared");

        // R4 event and clearing write in the same cycle
        sess_vld_pin = 1'b1;
        wait_cyc(2);
        bus_write('h604, 32'h1000);
        bus_read('h604, 32'h1000, "R4 event wins");
        bus_write('h604, 32'h1000);
        bus_read('h604, 32'h0, "R3 clear after collision");

        wait_cyc(3);
        finish_run();
    end
endmodule